// File: doc/BRIEF.md
# GPIO Port with Timer Pin Override

A seven-pin general-purpose I/O port controlled through two byte-wide registers on a simple register bus. The bus has an address, a write strobe, write data and combinational read data. One register is the output data latch. The other holds one direction bit per pin, and that bit enables the pin's output driver. Each pin presents output data and output enable to its pad, and returns an input sample. Every input sample passes through a two-flop synchronizer before it can be read.

Pins 4 and 5 can be handed to timer channels 0 and 1. A channel takes its pin whenever its two-bit edge/level select field is nonzero. While a channel owns its pin, the timer's enable and data drive the pad and the direction bit has no effect on it. Reads of the data register follow the direction bits for every pin, owned or not. A 1 returns the latch and a 0 returns the synchronized pin level.

Software can write the latch while a pin is still an input, then set the direction bit. The pad then starts driving the intended value on the first cycle it is enabled.

Top module: `gpio_ovr_port`

## Requirements
- R1: While reset is asserted and after it is released, every direction bit and latch bit is 0. With no timer ownership, all pins are inputs and drive 0.
- R2: The direction register is at address 0xD. Bits 6:0 read back as written. Bit 7 always reads 0, ignores writes, and is also 0 in data-register reads.
- R3: For a pin that no timer owns, output enable equals its direction bit (1 = output). It takes the new value right after the clock edge that captures the write.
- R4: The data latch is at address 0x5. A write updates it whatever the direction bits hold, and the latch drives the data of unowned pins.
- R5: A read of address 0x5 returns, per bit, the latch when the direction bit is 1 and the synchronized pin level when it is 0. A pin change first shows in the read after the second rising clock edge.
- R6: Channel 0 owns pin 4 when tmr_sel_i[1:0] is nonzero, and channel 1 owns pin 5 when tmr_sel_i[3:2] is nonzero. An owned pin's enable and data come from tmr_oe_i and tmr_do_i for that channel, and its direction bit is ignored. When the select field returns to zero, control goes back to the registers.
- R7: The R5 read rule also applies to pins that a timer owns.
- R8: A write to any address other than 0x5 and 0xD changes no state. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| pin_i | input | 7 | Pad input levels |
| pin_o | output | 7 | Pad output data |
| pin_oe_o | output | 7 | Pad output enable |
| tmr_sel_i | input | 4 | Edge/level select fields, two bits per channel |
| tmr_oe_i | input | 2 | Timer output enable per channel |
| tmr_do_i | input | 2 | Timer output data per channel |

## Verification
The assertions check on every cycle that reset clears both registers and that bit 7 never reads as 1. They also check that a direction or latch write appears on the unowned pads one cycle later, that owned pins follow the timer inputs, and that writes to unused addresses leave both registers unchanged. Only the bench scenarios can show the two-edge latency of the input path and the per-bit read selection, including for owned pins. The same goes for the absence of an enable/data glitch when the latch is preloaded before the pins are enabled, and for the handover back to register control when a select field drops to zero.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
  localparam int unsigned PORT_W   = 7;
  localparam int unsigned BUS_W    = 8;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned N_CH     = 2;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned TMR_PIN0 = 4;
  localparam int unsigned SYNC_N   = 2;
  localparam logic [ADDR_W-1:0] DATA_OFS = 4'h5;
  localparam logic [ADDR_W-1:0] DIR_OFS  = 4'hD;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/gpio_ovr_regs.sv
module gpio_ovr_regs
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned WIDTH = PORT_W,
  parameter int unsigned AW    = ADDR_W,
  parameter logic [AW-1:0] D_OFS = DATA_OFS,
  parameter logic [AW-1:0] R_OFS = DIR_OFS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wdata_i,
  output reg_sel_e         sel_o,
  output logic [WIDTH-1:0] lat_q_o,
  output logic [WIDTH-1:0] dir_q_o
);
  reg_sel_e sel;

  always_comb begin
    if (addr_i == D_OFS)      sel = SEL_DATA;
    else if (addr_i == R_OFS) sel = SEL_DIR;
    else                      sel = SEL_NONE;
  end

  // latch accepts writes regardless of direction (allows preload)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q_o <= '0;
      dir_q_o <= '0;
    end else if (wr_en_i) begin
      if (sel == SEL_DATA) lat_q_o <= wdata_i;
      if (sel == SEL_DIR)  dir_q_o <= wdata_i;
    end
  end

  assign sel_o = sel;
endmodule

// File: rtl/gpio_ovr_sync.sv
module gpio_ovr_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_ovr_pin_mux.sv
module gpio_ovr_pin_mux
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned WIDTH = PORT_W,
  parameter int unsigned NCH   = N_CH,
  parameter int unsigned SW    = SEL_W,
  parameter int unsigned PIN0  = TMR_PIN0
) (
  input  logic [WIDTH-1:0]  lat_i,
  input  logic [WIDTH-1:0]  dir_i,
  input  logic [NCH*SW-1:0] tmr_sel_i,
  input  logic [NCH-1:0]    tmr_oe_i,
  input  logic [NCH-1:0]    tmr_do_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    if (i >= PIN0 && i < PIN0 + NCH) begin : g_tmr
      localparam int unsigned CH = i - PIN0;
      logic owned;
      assign owned       = |tmr_sel_i[CH*SW +: SW];
      assign pin_oe_o[i] = owned ? tmr_oe_i[CH] : dir_i[i];
      assign pin_o[i]    = owned ? tmr_do_i[CH] : lat_i[i];
    end else begin : g_gpio
      assign pin_oe_o[i] = dir_i[i];
      assign pin_o[i]    = lat_i[i];
    end
  end
endmodule

// File: rtl/gpio_ovr_port.sv
module gpio_ovr_port
  import gpio_ovr_pkg::*;
#(
  parameter int unsigned WIDTH = PORT_W,
  parameter int unsigned DW    = BUS_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned NCH   = N_CH,
  parameter int unsigned SW    = SEL_W,
  parameter int unsigned PIN0  = TMR_PIN0,
  parameter int unsigned SYNC  = SYNC_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              wr_en_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_o,
  output logic [WIDTH-1:0]  pin_oe_o,
  input  logic [NCH*SW-1:0] tmr_sel_i,
  input  logic [NCH-1:0]    tmr_oe_i,
  input  logic [NCH-1:0]    tmr_do_i
);
  localparam int unsigned PAD_W = DW - WIDTH;

  reg_sel_e         sel;
  logic [WIDTH-1:0] lat_q, dir_q, pin_sync, rd_port;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:WIDTH];

  gpio_ovr_regs #(.WIDTH(WIDTH), .AW(AW)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i[WIDTH-1:0]),
    .sel_o   (sel),
    .lat_q_o (lat_q),
    .dir_q_o (dir_q)
  );

  gpio_ovr_sync #(.WIDTH(WIDTH), .STAGES(SYNC)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_ovr_pin_mux #(.WIDTH(WIDTH), .NCH(NCH), .SW(SW), .PIN0(PIN0)) mux_i (
    .lat_i     (lat_q),
    .dir_i     (dir_q),
    .tmr_sel_i (tmr_sel_i),
    .tmr_oe_i  (tmr_oe_i),
    .tmr_do_i  (tmr_do_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o)
  );

  // read select follows direction bits only, never ownership
  assign rd_port = (dir_q & lat_q) | (~dir_q & pin_sync);

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata_o = {{PAD_W{1'b0}}, rd_port};
      SEL_DIR:  rdata_o = {{PAD_W{1'b0}}, dir_q};
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_ovr_port_chk.sv
module gpio_ovr_port_chk #(
  parameter int unsigned WIDTH = 7,
  parameter int unsigned AW    = 4,
  parameter int unsigned NCH   = 2,
  parameter int unsigned SW    = 2,
  parameter int unsigned PIN0  = 4,
  parameter logic [AW-1:0] D_OFS = 4'h5,
  parameter logic [AW-1:0] R_OFS = 4'hD
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [AW-1:0]     addr_i,
  input logic              wr_en_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic              rdata7_i,
  input logic [WIDTH-1:0]  pin_o,
  input logic [WIDTH-1:0]  pin_oe_o,
  input logic [NCH*SW-1:0] tmr_sel_i,
  input logic [NCH-1:0]    tmr_oe_i,
  input logic [NCH-1:0]    tmr_do_i,
  input logic [WIDTH-1:0]  dir_q,
  input logic [WIDTH-1:0]  lat_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (dir_q == '0 && lat_q == '0));

  // R2
  dir_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == R_OFS) |=> dir_q == $past(wdata_i));

  // R2
  bit7_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata7_i);

  // R3
  oe_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == R_OFS) |=> pin_oe_o[PIN0-1:0] == $past(wdata_i[PIN0-1:0]));

  // R4
  lat_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == D_OFS) |=> pin_o[PIN0-1:0] == $past(wdata_i[PIN0-1:0]));

  // R6
  ch0_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tmr_sel_i[SW-1:0]) |-> (pin_oe_o[PIN0] == tmr_oe_i[0] && pin_o[PIN0] == tmr_do_i[0]));

  // R6
  ch1_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tmr_sel_i[2*SW-1:SW]) |-> (pin_oe_o[PIN0+1] == tmr_oe_i[1] && pin_o[PIN0+1] == tmr_do_i[1]));

  // R8
  stray_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i != D_OFS && addr_i != R_OFS) |=> ($stable(dir_q) && $stable(lat_q)));
endmodule

bind gpio_ovr_port gpio_ovr_port_chk #(
  .WIDTH(WIDTH), .AW(AW), .NCH(NCH), .SW(SW), .PIN0(PIN0)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i[WIDTH-1:0]),
  .rdata7_i  (rdata_o[DW-1]),
  .pin_o     (pin_o),
  .pin_oe_o  (pin_oe_o),
  .tmr_sel_i (tmr_sel_i),
  .tmr_oe_i  (tmr_oe_i),
  .tmr_do_i  (tmr_do_i),
  .dir_q     (dir_q),
  .lat_q     (lat_q)
);

// File: tb/gpio_ovr_port_tb_top.sv
`timescale 1ns/1ps
module gpio_ovr_port_tb_top;
  localparam time CLK_P = 4ns;
  localparam logic [3:0] A_DATA = 4'h5;
  localparam logic [3:0] A_DIR  = 4'hD;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = 4'hF;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [6:0] pin_i = '0;
  logic [6:0] pin_o, pin_oe_o;
  logic [3:0] tmr_sel_i = '0;
  logic [1:0] tmr_oe_i = '0;
  logic [1:0] tmr_do_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  int glitches = 0;
  bit mon_en = 1'b0;
  logic [6:0] mon_exp = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  gpio_ovr_port dut_i (.*);

  // any enabled pin showing a value other than the preloaded one is a glitch
  always @(pin_o or pin_oe_o)
    if (mon_en && ((pin_oe_o & (pin_o ^ mon_exp)) != '0)) glitches++;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 4'hF;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1;
    check("R1 oe in reset", {1'b0, pin_oe_o}, 8'h00);
    check("R1 data in reset", {1'b0, pin_o}, 8'h00);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd(A_DIR, v);  check("R1 dir after reset", v, 8'h00);
    rd(A_DATA, v); check("R1 data read after reset", v, 8'h00);
    check("R1 oe after reset", {1'b0, pin_oe_o}, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    wr(A_DIR, 8'hFF);
    rd(A_DIR, v); check("R2 dir readback all ones, bit7 zero", v, 8'h7F);
    check("R3 oe all outputs", {1'b0, pin_oe_o}, 8'h7F);
    wr(A_DIR, 8'h2A);
    rd(A_DIR, v); check("R2 dir readback pattern", v, 8'h2A);
    check("R3 oe pattern", {1'b0, pin_oe_o}, 8'h2A);
    wr(A_DIR, 8'h80);
    rd(A_DIR, v); check("R2 bit7 write ignored", v, 8'h00);
    check("R3 oe all inputs", {1'b0, pin_oe_o}, 8'h00);
  endtask

  task automatic t_preload();
    wr(A_DATA, 8'h55);
    check("R4 latch updated while input", {1'b0, pin_o}, 8'h55);
    check("R4 still undriven", {1'b0, pin_oe_o}, 8'h00);
    mon_exp = 7'h55; mon_en = 1'b1;
    wr(A_DIR, 8'h7F);
    check("R4 enable after preload oe", {1'b0, pin_oe_o}, 8'h7F);
    check("R4 enable after preload data", {1'b0, pin_o}, 8'h55);
    mon_en = 1'b0;
    check("R4 no glitch on enable", 8'(glitches), 8'h00);
    wr(A_DIR, 8'h00);
  endtask

  task automatic t_read();
    logic [7:0] v;
    wr(A_DIR, 8'h0F);
    @(negedge clk_i);
    pin_i = 7'h2A;
    @(negedge clk_i);
    rd(A_DATA, v); check("R5 one edge, old pin level", v, 8'h05);
    @(negedge clk_i);
    rd(A_DATA, v); check("R5 two edges, new pin level", v, 8'h25);
    pin_i = 7'h7F;
    repeat (2) @(negedge clk_i);
    rd(A_DATA, v); check("R5 latch bits hold for outputs", v, 8'h75);
    pin_i = '0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_owner();
    logic [7:0] v;
    wr(A_DATA, 8'h20);
    wr(A_DIR, 8'h20);
    pin_i = 7'h10;
    repeat (2) @(negedge clk_i);
    tmr_sel_i = 4'b0101; tmr_oe_i = 2'b11; tmr_do_i = 2'b01;
    #1;
    check("R6 owned oe", {6'b0, pin_oe_o[5:4]}, 8'h03);
    check("R6 owned data", {6'b0, pin_o[5:4]}, 8'h01);
    rd(A_DATA, v); check("R7 read while owned", v, 8'h30);
    tmr_oe_i = 2'b00;
    #1;
    check("R6 dir bit ignored when owned", {6'b0, pin_oe_o[5:4]}, 8'h00);
    tmr_sel_i = 4'b1000; tmr_oe_i = 2'b11;
    pin_i = 7'h00;
    #1;
    check("R6 only ch1 owns oe", {6'b0, pin_oe_o[5:4]}, 8'h02);
    check("R6 only ch1 owns data", {6'b0, pin_o[5:4]}, 8'h00);
    repeat (2) @(negedge clk_i);
    rd(A_DATA, v); check("R7 owned pin read follows latch", v, 8'h20);
    tmr_sel_i = 4'b0000;
    #1;
    check("R6 handback oe", {6'b0, pin_oe_o[5:4]}, 8'h02);
    check("R6 handback data", {6'b0, pin_o[5:4]}, 8'h02);
    tmr_oe_i = '0; tmr_do_i = '0;
  endtask

  task automatic t_decode();
    logic [7:0] v;
    wr(4'h3, 8'hFF);
    wr(4'hE, 8'hFF);
    rd(A_DIR, v); check("R8 dir untouched by stray write", v, 8'h20);
    check("R8 latch untouched by stray write", {1'b0, pin_o}, 8'h20);
    rd(4'h3, v); check("R8 unmapped read is zero", v, 8'h00);
    rd(A_DATA, v); check("R2 data read bit7 zero", {v[7], 7'b0}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_dir();
    t_preload();
    t_read();
    t_owner();
    t_decode();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule